// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one channel of a high-precision event timer. It watches a shared 64-bit free-running counter supplied from outside and latches an expiry when the counter reaches a programmed match point. It can fire once or reload itself periodically. A 32-bit mode matches on the low half of the counter only.

Software programs the channel through a small register port with byte-lane write enables. The port gives access to a configuration word, the comparator, a period value and a status bit that is cleared by writing a one. The channel keeps a hidden 64-bit target derived from the comparator, and a hidden wrap flag. In one-shot 32-bit mode it signals the counter's 32-bit rollover before the real match. In periodic mode it catches up on missed periods by adding the period once per cycle.

The counter, the block-level enable and interrupt delivery sit outside this block.

Top module: `hpet_chan`

## Requirements
- R1: After reset, the configuration reads 0, the comparator reads all ones, the period reads 0, the status bit reads 0 and `irq` is 0.
- R2: Register addresses are 0 for configuration, 1 for comparator, 2 for period and 3 for status. Configuration bit 0 is interrupt enable, bit 1 selects periodic mode and bit 2 selects 32-bit mode; the configuration is written only when byte lane 0 is enabled. A comparator write changes only the bytes whose `wr_be` bit is set. The period register is read-only through address 2. Unused read bits are 0.
- R3: In 64-bit mode the target equals the comparator. Arming takes effect at the second rising edge after the write edge. The status bit is set at the first later edge where the sampled counter minus the active match point, read as a signed 64-bit value, is at least zero.
- R4: In 32-bit mode the target is the sampled counter with its low 32 bits replaced by the comparator's low 32 bits, plus 2^32 if that value is below the counter.
- R5: In 32-bit one-shot mode, if the target lies beyond the next 32-bit rollover point of the counter, the channel first fires when the counter reaches that rollover point. It then re-arms on the real target and fires again there.
- R6: In periodic mode with a nonzero period, after a fire the target gains the period once per cycle until it is ahead of the counter. The new target is then written to the comparator (low 32 bits only in 32-bit mode) and becomes the next match point.
- R7: A comparator write while periodic mode is selected also writes the period through the same byte lanes. In a one-shot write the period is left unchanged. In 32-bit mode, byte lanes 4 to 7 of comparator and period writes are ignored.
- R8: A configuration write that selects 32-bit mode clears the upper 32 bits of both the comparator and the period.
- R9: The status bit stays set until a write to address 3 with lane 0 enabled and data bit 0 set. A fire in the same cycle as the clear wins. `irq` is the status bit gated by the interrupt-enable bit.
- R10: A configuration or comparator write, or a rising edge of `blk_en`, recomputes and arms the channel only while `blk_en` is high. While `blk_en` is low nothing fires.
- R11: No fire is signalled while a periodic catch-up is in progress.
- R12: A one-shot channel without a pending wrap fires once and then stays disarmed until re-armed. A periodic channel with a zero period behaves the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt | input | 64 | Shared free-running main counter |
| blk_en | input | 1 | Timer block enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 64 | Write data |
| wr_be | input | 8 | Byte-lane write enables |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 64 | Read data (combinational) |
| irq | output | 1 | Interrupt request, status gated by enable |
| irq_status | output | 1 | Latched expiry status |

## Verification
A wrong hidden target, wrap flag or catch-up state can only become visible at the ports as a fire in the wrong cycle. The bench therefore pins the status bit exactly one cycle before and one cycle after each expected match, in both modes, at a 32-bit rollover and after a catch-up. Any off-by-one or wrong splice shows up as a status mismatch within one clock. A wrong catch-up result is also visible early, because the comparator is written back and the bench reads it before the next period expires. A lockstep behavioural model compares `irq` and `irq_status` on every cycle, so a stray refire during catch-up is caught in the cycle after it happens.

// File: rtl/hpet_chan.sv
module hpet_chan #(
  parameter int CW = 64,
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW-1:0]   cnt,
  input  logic            blk_en,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [CW-1:0]   wr_data,
  input  logic [CW/8-1:0] wr_be,
  input  logic [1:0]      rd_addr,
  output logic [CW-1:0]   rd_data,
  output logic            irq,
  output logic            irq_status
);
  localparam int NB = CW / 8;
  localparam logic [CW-1:0] LO     = {{(CW-HW){1'b0}}, {HW{1'b1}}};
  localparam logic [CW-1:0] ONE    = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] STEP32 = LO + ONE;
  localparam logic [1:0] A_CFG = 2'd0, A_CMP = 2'd1, A_PER = 2'd2, A_STS = 2'd3;

  logic          cfg_ie, cfg_per, cfg_m32;
  logic [CW-1:0] cmp_q, per_q, tgt_q, arm_q;
  logic          armed_q, busy_q, wrap_q, recalc_q, en_q, sts_q;

  logic [CW-1:0] bmask, wmask, cmp_merge, per_merge;
  logic [CW-1:0] splice, t32, next_wrap, new_tgt, d_arm, d_tgt;
  logic          hit, behind, need_wrap;
  logic          wr_cfg, wr_cmp, wr_clr;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign bmask[b*8 +: 8] = {8{wr_be[b]}};
  end

  assign wmask     = cfg_m32 ? (bmask & LO) : bmask;
  assign cmp_merge = (cmp_q & ~wmask) | (wr_data & wmask);
  assign per_merge = (per_q & ~wmask) | (wr_data & wmask);

  assign wr_cfg = wr_en && wr_addr == A_CFG;
  assign wr_cmp = wr_en && wr_addr == A_CMP;
  assign wr_clr = wr_en && wr_addr == A_STS && wr_be[0] && wr_data[0];

  assign splice    = {cnt[CW-1:HW], cmp_q[HW-1:0]};
  assign t32       = (splice < cnt) ? splice + STEP32 : splice;
  assign next_wrap = (cnt | LO) + ONE;
  assign new_tgt   = cfg_m32 ? t32 : cmp_q;
  assign need_wrap = cfg_m32 && !cfg_per && (t32 > next_wrap);

  assign d_arm  = cnt - arm_q;
  assign d_tgt  = cnt - tgt_q;
  assign behind = !d_tgt[CW-1];
  assign hit    = blk_en && armed_q && !busy_q && !recalc_q && !d_arm[CW-1];

  assign irq_status = sts_q;
  assign irq        = sts_q & cfg_ie;

  always_comb begin
    case (rd_addr)
      A_CFG:   rd_data = {{(CW-3){1'b0}}, cfg_m32, cfg_per, cfg_ie};
      A_CMP:   rd_data = cmp_q;
      A_PER:   rd_data = per_q;
      default: rd_data = {{(CW-1){1'b0}}, sts_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_ie   <= 1'b0;
      cfg_per  <= 1'b0;
      cfg_m32  <= 1'b0;
      cmp_q    <= '1;
      per_q    <= '0;
      tgt_q    <= '0;
      arm_q    <= '0;
      armed_q  <= 1'b0;
      busy_q   <= 1'b0;
      wrap_q   <= 1'b0;
      recalc_q <= 1'b0;
      en_q     <= 1'b0;
      sts_q    <= 1'b0;
    end else begin
      en_q     <= blk_en;
      recalc_q <= blk_en && (wr_cfg || wr_cmp || !en_q);

      if (!blk_en) begin
        armed_q <= 1'b0;
        busy_q  <= 1'b0;
      end else if (recalc_q) begin
        tgt_q   <= new_tgt;
        wrap_q  <= need_wrap;
        arm_q   <= need_wrap ? next_wrap : new_tgt;
        armed_q <= 1'b1;
        busy_q  <= 1'b0;
      end else if (busy_q) begin
        if (behind) begin
          tgt_q <= tgt_q + per_q;
        end else begin
          busy_q <= 1'b0;
          arm_q  <= tgt_q;
          cmp_q  <= cfg_m32 ? (tgt_q & LO) : tgt_q;
        end
      end else if (hit) begin
        if (cfg_per && per_q != '0) begin
          busy_q <= 1'b1;
        end else if (wrap_q) begin
          wrap_q <= 1'b0;
          arm_q  <= tgt_q;
        end else begin
          armed_q <= 1'b0;
        end
      end

      if (hit)         sts_q <= 1'b1;
      else if (wr_clr) sts_q <= 1'b0;

      if (wr_cfg && wr_be[0]) begin
        cfg_ie  <= wr_data[0];
        cfg_per <= wr_data[1];
        cfg_m32 <= wr_data[2];
        if (wr_data[2]) begin
          cmp_q <= cmp_q & LO;
          per_q <= per_q & LO;
        end
      end

      if (wr_cmp) begin
        cmp_q <= cmp_merge;
        if (cfg_per) per_q <= per_merge;
      end
    end
  end

  // R8
  m32_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_m32 |-> (cmp_q[CW-1:HW] == '0 && per_q[CW-1:HW] == '0));

  // R9
  sts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(armed_q && blk_en));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cfg_per && per_q != '0));

  // R5
  wrap_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrap_q) |-> $past(cfg_m32 && !cfg_per));

  // R11
  quiet_catchup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> !$past(busy_q));

  // R10
  off_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q) |-> $past(blk_en));
endmodule

// File: tb/hpet_chan_bench.sv
`timescale 1ns/1ps
module hpet_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic [63:0] step = 64'd1;
  logic        blk_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_be = '0;
  logic [1:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        irq, irq_status;

  always #2.5 clk = ~clk;

  hpet_chan u_hpet_chan (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .blk_en(blk_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .irq_status(irq_status)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  bit          m_ie, m_pe, m_m32, m_armed, m_busy, m_wrap, m_rc, m_en, m_sts;
  logic [63:0] m_cmp, m_per, m_tgt, m_arm;

  task automatic model_step();
    logic [63:0] ncmp = m_cmp, nper = m_per, ntgt = m_tgt, narm = m_arm;
    logic [63:0] t, nw, mask;
    bit narmed = m_armed, nbusy = m_busy, nwrap = m_wrap, nsts = m_sts;
    bit fire;
    fire = blk_en && m_armed && !m_busy && !m_rc && (longint'(cnt - m_arm) >= 0);
    if (!blk_en) begin
      narmed = 0; nbusy = 0;
    end else if (m_rc) begin
      if (m_m32) begin
        t = {cnt[63:32], m_cmp[31:0]};
        if (t < cnt) t = t + 64'h1_0000_0000;
      end else t = m_cmp;
      nw = {cnt[63:32] + 32'd1, 32'd0};
      ntgt = t;
      nwrap = m_m32 && !m_pe && (t > nw);
      narm = nwrap ? nw : t;
      narmed = 1; nbusy = 0;
    end else if (m_busy) begin
      if (longint'(cnt - m_tgt) >= 0) ntgt = m_tgt + m_per;
      else begin
        nbusy = 0; narm = m_tgt;
        ncmp = m_m32 ? {32'd0, m_tgt[31:0]} : m_tgt;
      end
    end else if (fire) begin
      if (m_pe && m_per != 0) nbusy = 1;
      else if (m_wrap) begin nwrap = 0; narm = m_tgt; end
      else narmed = 0;
    end
    if (fire) nsts = 1;
    else if (wr_en && wr_addr == 2'd3 && wr_be[0] && wr_data[0]) nsts = 0;
    if (wr_en && wr_addr == 2'd0 && wr_be[0]) begin
      if (wr_data[2]) begin
        ncmp = {32'd0, m_cmp[31:0]};
        nper = {32'd0, m_per[31:0]};
      end
      m_ie = wr_data[0]; m_pe = wr_data[1]; m_m32 = wr_data[2];
    end
    if (wr_en && wr_addr == 2'd1) begin
      for (int b = 0; b < 8; b++) begin
        if (wr_be[b] && !(b >= 4 && m_m32_old_chk(b))) begin
          ncmp[b*8 +: 8] = wr_data[b*8 +: 8];
          if (m_pe) nper[b*8 +: 8] = wr_data[b*8 +: 8];
        end
      end
    end
    mask = '0;
    m_rc = blk_en && ((wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1)) || !m_en);
    m_en = blk_en;
    m_cmp = ncmp; m_per = nper; m_tgt = ntgt; m_arm = narm;
    m_armed = narmed; m_busy = nbusy; m_wrap = nwrap; m_sts = nsts;
  endtask

  function automatic bit m_m32_old_chk(input int b);
    return (b >= 4) && m_m32;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ie = 0; m_pe = 0; m_m32 = 0; m_armed = 0; m_busy = 0; m_wrap = 0;
      m_rc = 0; m_en = 0; m_sts = 0;
      m_cmp = '1; m_per = '0; m_tgt = '0; m_arm = '0;
    end else begin
      model_step();
    end
  end

  // R9 lockstep comparison of both outputs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq_status === m_sts, "R9 status vs model", {63'd0, irq_status}, {63'd0, m_sts});
      chk(irq === (m_sts & m_ie), "R9 irq vs model", {63'd0, irq}, {63'd0, m_sts & m_ie});
    end
  end

  task automatic tick();
    @(negedge clk);
    cnt = cnt + step;
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    cnt = cnt + step;
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    tick();
  endtask

  task automatic setc(input logic [63:0] v);
    @(negedge clk);
    cnt = v;
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input logic [63:0] v);
    while (cnt < v) tick();
  endtask

  task automatic rdchk(input logic [1:0] a, input logic [63:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data === exp, tag, rd_data, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rdchk(2'd0, 64'd0, "R1 cfg reset");
    rdchk(2'd1, '1, "R1 cmp reset");
    rdchk(2'd2, 64'd0, "R1 period reset");
    rdchk(2'd3, 64'd0, "R1 status reset");
    chk(irq === 1'b0, "R1 irq reset", {63'd0, irq}, 64'd0);

    // R10 no arming while disabled, enable edge arms
    wr(2'd0, 64'd1, 8'h01);
    wr(2'd1, cnt + 64'd10, 8'hFF);
    ticks(30);
    rdchk(2'd3, 64'd0, "R10 disabled no fire");
    blk_en = 1'b1;
    ticks(4);
    rdchk(2'd3, 64'd1, "R10 enable edge arms");
    chk(irq === 1'b1, "R9 irq when enabled", {63'd0, irq}, 64'd1);
    wr(2'd3, 64'd1, 8'h01);
    rdchk(2'd3, 64'd0, "R9 write one clears");

    // R3 64-bit one-shot exact boundary
    setc(64'd1000);
    wr(2'd1, 64'd1040, 8'hFF);
    wait_cnt(64'd1040);
    rdchk(2'd3, 64'd0, "R3 before match");
    wait_cnt(64'd1041);
    rdchk(2'd3, 64'd1, "R3 at match");
    wr(2'd3, 64'd1, 8'h01);
    ticks(50);
    rdchk(2'd3, 64'd0, "R12 one-shot no refire");

    // R9 enable gating
    wr(2'd0, 64'd0, 8'h01);
    wr(2'd1, cnt + 64'd5, 8'hFF);
    ticks(20);
    rdchk(2'd3, 64'd1, "R9 status held");
    chk(irq === 1'b0, "R9 irq gated", {63'd0, irq}, 64'd0);
    wr(2'd3, 64'd1, 8'h01);
    rdchk(2'd3, 64'd0, "R9 cleared");

    // R2 byte lanes, R7 one-shot leaves period
    wr(2'd1, 64'h1111_2222_3333_4444, 8'hFF);
    wr(2'd1, 64'hAAAA_AAAA_AAAA_AAAA, 8'h0F);
    rdchk(2'd1, 64'h1111_2222_AAAA_AAAA, "R2 byte lanes");
    rdchk(2'd2, 64'd0, "R7 period untouched in one-shot");
    wr(2'd2, 64'd5, 8'hFF);
    rdchk(2'd2, 64'd0, "R2 period read-only");

    // R7 periodic write updates period, R8 truncation
    wr(2'd0, 64'd2, 8'h01);
    wr(2'd1, 64'h0000_0007_0000_0100, 8'hFF);
    rdchk(2'd2, 64'h0000_0007_0000_0100, "R7 period follows cmp");
    wr(2'd0, 64'd6, 8'h01);
    rdchk(2'd1, 64'h100, "R8 cmp truncated");
    rdchk(2'd2, 64'h100, "R8 period truncated");
    rdchk(2'd0, 64'd6, "R2 cfg readback");
    wr(2'd1, 64'hFFFF_FFFF_0000_0200, 8'hFF);
    rdchk(2'd1, 64'h200, "R7 upper lanes ignored cmp");
    rdchk(2'd2, 64'h200, "R7 upper lanes ignored period");

    // R4 32-bit splice without wrap
    blk_en = 1'b0;
    setc(64'h3_0000_0100);
    wr(2'd0, 64'd5, 8'h01);
    wr(2'd1, 64'h200, 8'hFF);
    blk_en = 1'b1;
    wait_cnt(64'h3_0000_0200);
    rdchk(2'd3, 64'd0, "R4 before low-half match");
    wait_cnt(64'h3_0000_0201);
    rdchk(2'd3, 64'd1, "R4 low-half match");
    wr(2'd3, 64'd1, 8'h01);

    // R5 wrap first, then real target
    blk_en = 1'b0;
    setc(64'h5_FFFF_FF00);
    wr(2'd1, 64'h40, 8'hFF);
    blk_en = 1'b1;
    wait_cnt(64'h6_0000_0000);
    rdchk(2'd3, 64'd0, "R5 before rollover");
    wait_cnt(64'h6_0000_0001);
    rdchk(2'd3, 64'd1, "R5 rollover fire");
    wr(2'd3, 64'd1, 8'h01);
    wait_cnt(64'h6_0000_0040);
    rdchk(2'd3, 64'd0, "R5 before real target");
    wait_cnt(64'h6_0000_0041);
    rdchk(2'd3, 64'd1, "R5 real target");
    wr(2'd3, 64'd1, 8'h01);

    // R6 / R11 periodic catch-up with frozen counter
    blk_en = 1'b0;
    step = 64'd0;
    setc(64'd1000);
    wr(2'd0, 64'd3, 8'h01);
    wr(2'd1, 64'd16, 8'hFF);
    rdchk(2'd2, 64'd16, "R7 period set");
    blk_en = 1'b1;
    ticks(3);
    wr(2'd3, 64'd1, 8'h01);
    ticks(100);
    rdchk(2'd3, 64'd0, "R11 no fire during catch-up");
    rdchk(2'd1, 64'd1008, "R6 catch-up write-back");
    step = 64'd1;
    wait_cnt(64'd1008);
    rdchk(2'd3, 64'd0, "R6 before period match");
    wait_cnt(64'd1009);
    rdchk(2'd3, 64'd1, "R6 period match");
    wr(2'd3, 64'd1, 8'h01);
    wait_cnt(64'd1020);
    rdchk(2'd1, 64'd1024, "R6 reload");
    rdchk(2'd3, 64'd0, "R6 quiet between periods");
    wait_cnt(64'd1025);
    rdchk(2'd3, 64'd1, "R6 next period");

    // R12 periodic with zero period fires once
    blk_en = 1'b0;
    step = 64'd0;
    wr(2'd3, 64'd1, 8'h01);
    wr(2'd1, 64'd0, 8'hFF);
    rdchk(2'd2, 64'd0, "R7 zero period");
    blk_en = 1'b1;
    ticks(5);
    rdchk(2'd3, 64'd1, "R12 zero period single fire");
    wr(2'd3, 64'd1, 8'h01);
    ticks(20);
    rdchk(2'd3, 64'd0, "R12 zero period stays disarmed");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule